// File: doc/BRIEF.md
# Write Buffer with Read-Miss Forwarding

This block sits between a data cache and the next level of memory. The cache pushes store traffic into it, either write-through words or words of evicted dirty lines. The block holds up to `DEPTH` entries and sends them to memory oldest first. As long as an entry is free, the cache never waits on a store.

A read miss from the cache does not have to wait behind the queued stores. In the same cycle it arrives, its address is compared with every valid entry. If no entry holds that address, the read takes the memory port ahead of any pending drain. If one or more entries hold it, the newest of them answers the read, and memory sees no read at all. A parameter selects a simpler variant with no comparison: a read miss is held until the buffer has fully drained and is then served from memory.

The memory port uses a request/accept handshake. `mem_ack` accepts the request shown in the same cycle, and read data returns on `mem_rdata` in that cycle. A request that has not been accepted may be replaced in the next cycle.

Top module: `write_buffer`

## Requirements
- R1: With reset low, `wr_ready` is high whenever fewer than `DEPTH` entries are held, so a push completes in one cycle. With `DEPTH` entries held, `wr_ready` is low and the push waits.
- R2: Buffered writes go to memory in push order with `mem_req_we`=1 and the entry's address and data. One entry leaves per cycle in which `mem_ack` is high.
- R3: A read miss whose address matches no valid entry is presented on the memory port with `mem_req_we`=0. It takes the port even when a drain is pending. `rd_ready` rises in the cycle `mem_ack` is high. One cycle later, `rsp_valid` is high with `rsp_data` equal to the `mem_rdata` of the accepting cycle and `rsp_fwd`=0.
- R4: With forwarding enabled, a read miss that matches a valid entry gets `rd_ready` in its first cycle and issues no memory read. One cycle later it is answered with that entry's data and `rsp_fwd`=1.
- R5: When several valid entries hold the read address, the most recently pushed one supplies the data.
- R6: A matching entry that drains to memory in the same cycle still forwards its data to the read accepted in that cycle.
- R7: With forwarding disabled, a read miss is never shown to memory while any entry is held. It is served from memory (`rsp_fwd`=0) only after every earlier write has drained.
- R8: After reset, the buffer is empty, `wr_ready`=1, `mem_req_valid`=0 and `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Cache offers a store |
| wr_ready | output | 1 | Buffer has room; push completes this cycle |
| wr_addr | input | AW | Store address |
| wr_data | input | DW | Store data |
| rd_valid | input | 1 | Read miss pending; held until `rd_ready` |
| rd_ready | output | 1 | Read miss accepted this cycle |
| rd_addr | input | AW | Read-miss address |
| rsp_valid | output | 1 | Read response valid (one cycle after acceptance) |
| rsp_data | output | DW | Read response data |
| rsp_fwd | output | 1 | 1 = data came from the buffer, 0 = from memory |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_we | output | 1 | 1 = write (drain), 0 = read miss |
| mem_req_addr | output | AW | Memory request address |
| mem_req_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory accepts the current request this cycle |
| mem_rdata | input | DW | Memory read data, valid in the accepting cycle |

## Verification
Suppose the head pointer or an entry's valid bit is wrong. The next drain then carries the wrong address or data, or the drain comes out of order, and the scoreboard sees it at the first `mem_ack`. A wrong match order or a stale valid bit shows up in the `rsp_data`/`rsp_fwd` pair one cycle after the read is accepted. A lost read priority shows up as a write on the port in the very cycle a non-matching read is waiting. The directed cases target the points where these faults appear first: a full buffer, duplicate addresses, a drain and a forward of the same entry in one cycle, and the wait-for-empty variant.

// File: rtl/wb_pkg.sv
// Shared definitions for the write buffer.
// Assumes: nothing beyond the standard language.
package wb_pkg;

    // Opcode on the memory-side port; the encoding is driven onto mem_req_we.
    typedef enum logic {
        MEM_OP_READ  = 1'b0,
        MEM_OP_WRITE = 1'b1
    } mem_op_e;

endpackage

// File: rtl/wb_fifo.sv
// Circular entry store for the write buffer.
// Holds address/data pairs in push order. Every entry is exposed so that
// the read-miss search can compare against all of them.
// Assumes: the caller never pushes when full and never pops when empty.
module wb_fifo #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [AW-1:0]              push_addr,
    input  logic [DW-1:0]              push_data,
    input  logic                       pop,
    output logic [DEPTH-1:0][AW-1:0]   ent_addr,
    output logic [DEPTH-1:0][DW-1:0]   ent_data,
    output logic [DEPTH-1:0]           ent_valid,
    output logic [PW-1:0]              head,
    output logic                       empty,
    output logic                       full,
    output logic [AW-1:0]              head_addr,
    output logic [DW-1:0]              head_data
);

    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [PW-1:0] tail;
    logic [CW-1:0] count;

    // Pointer step with wrap at DEPTH, so any depth is supported.
    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + PW'(1);
    endfunction

    // Payload storage: write the tail slot on push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_addr <= '0;
            ent_data <= '0;
        end else if (push) begin
            ent_addr[tail] <= push_addr;
            ent_data[tail] <= push_data;
        end
    end

    // Valid bits: set the tail slot on push, clear the head slot on pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_valid <= '0;
        end else begin
            if (push) ent_valid[tail] <= 1'b1;
            if (pop)  ent_valid[head] <= 1'b0;
        end
    end

    // Pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= step(tail);
            if (pop)  head <= step(head);
            case ({push, pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    assign empty     = (count == '0);
    assign full      = (count == CW'(DEPTH));
    assign head_addr = ent_addr[head];
    assign head_data = ent_data[head];

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

    // R2
    count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ent_valid) == int'(count));

endmodule

// File: rtl/wb_match.sv
// Associative search of the buffered writes for a read-miss address.
// Walks the entries from oldest to youngest, so the last hit found is the
// most recently pushed one and supplies the forwarded data.
// Assumes: head points at the oldest entry; invalid slots never match.
module wb_match #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int SW   = PW + 1
) (
    input  logic [AW-1:0]              lookup_addr,
    input  logic [DEPTH-1:0][AW-1:0]   ent_addr,
    input  logic [DEPTH-1:0][DW-1:0]   ent_data,
    input  logic [DEPTH-1:0]           ent_valid,
    input  logic [PW-1:0]              head,
    output logic                       hit,
    output logic [DW-1:0]              hit_data
);

    // Age-ordered compare: later (younger) matches override earlier ones.
    always_comb begin
        logic [SW-1:0] pos;
        logic [PW-1:0] idx;
        hit      = 1'b0;
        hit_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            pos = {1'b0, head} + SW'(i);
            if (pos >= SW'(DEPTH)) pos = pos - SW'(DEPTH);
            idx = pos[PW-1:0];
            if (ent_valid[idx] && (ent_addr[idx] == lookup_addr)) begin
                hit      = 1'b1;
                hit_data = ent_data[idx];
            end
        end
    end

endmodule

// File: rtl/wb_mem_arb.sv
// Memory-port arbiter for the write buffer.
// A read miss that needs memory wins the port over a pending drain.
// Assumes: mem_ack accepts whatever request is shown in the same cycle.
module wb_mem_arb
    import wb_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          rd_go,
    input  logic [AW-1:0] rd_addr,
    input  logic          drain_avail,
    input  logic [AW-1:0] head_addr,
    input  logic [DW-1:0] head_data,
    input  logic          mem_ack,
    output logic          mem_req_valid,
    output logic          mem_req_we,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    output logic          rd_grant,
    output logic          drain_pop
);

    mem_op_e op;

    // Pick the request source: the read first, then the oldest write.
    always_comb begin
        op            = rd_go ? MEM_OP_READ : MEM_OP_WRITE;
        mem_req_valid = rd_go | drain_avail;
        mem_req_addr  = rd_go ? rd_addr : head_addr;
        mem_req_wdata = rd_go ? '0 : head_data;
    end

    assign mem_req_we = (op == MEM_OP_WRITE);
    assign rd_grant   = rd_go & mem_ack;
    assign drain_pop  = ~rd_go & drain_avail & mem_ack;

endmodule

// File: rtl/write_buffer.sv
// Write buffer between a data cache and memory, with read-miss handling.
// Stores are queued and drained oldest first. With FORWARD_EN=1 a read miss
// is answered from the newest matching entry, or goes to memory ahead of
// the queue when nothing matches. With FORWARD_EN=0 a read miss waits until
// the queue is empty. A read does not see a write pushed in the same cycle.
// Assumes: rd_valid and rd_addr are held until rd_ready.
module write_buffer #(
    parameter int AW         = 32,
    parameter int DW         = 32,
    parameter int DEPTH      = 4,
    parameter bit FORWARD_EN = 1'b1,
    localparam int PW        = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    output logic          wr_ready,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_valid,
    output logic          rd_ready,
    input  logic [AW-1:0] rd_addr,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          rsp_fwd,
    output logic          mem_req_valid,
    output logic          mem_req_we,
    output logic [AW-1:0] mem_req_addr,
    output logic [DW-1:0] mem_req_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);

    logic [DEPTH-1:0][AW-1:0] ent_addr;
    logic [DEPTH-1:0][DW-1:0] ent_data;
    logic [DEPTH-1:0]         ent_valid;
    logic [PW-1:0]            head;
    logic                     empty, full;
    logic [AW-1:0]            head_addr;
    logic [DW-1:0]            head_data;
    logic                     push, drain_pop, rd_grant;
    logic                     rd_hit, rd_go;
    logic [DW-1:0]            fwd_data;
    logic                     rd_take;

    assign wr_ready = ~full;
    assign push     = wr_valid & ~full;

    wb_fifo #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (wr_addr),
        .push_data (wr_data),
        .pop       (drain_pop),
        .ent_addr  (ent_addr),
        .ent_data  (ent_data),
        .ent_valid (ent_valid),
        .head      (head),
        .empty     (empty),
        .full      (full),
        .head_addr (head_addr),
        .head_data (head_data)
    );

    generate
        if (FORWARD_EN) begin : g_fwd
            logic          match_hit;
            logic [DW-1:0] match_data;

            wb_match #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_match (
                .lookup_addr (rd_addr),
                .ent_addr    (ent_addr),
                .ent_data    (ent_data),
                .ent_valid   (ent_valid),
                .head        (head),
                .hit         (match_hit),
                .hit_data    (match_data)
            );

            assign rd_hit   = rd_valid & match_hit;
            assign rd_go    = rd_valid & ~match_hit;
            assign fwd_data = match_data;
        end else begin : g_wait
            assign rd_hit   = 1'b0;
            assign rd_go    = rd_valid & empty;
            assign fwd_data = '0;

            // R7
            wait_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (mem_req_valid && !mem_req_we) |-> empty);
        end
    endgenerate

    wb_mem_arb #(.AW(AW), .DW(DW)) u_arb (
        .rd_go         (rd_go),
        .rd_addr       (rd_addr),
        .drain_avail   (~empty),
        .head_addr     (head_addr),
        .head_data     (head_data),
        .mem_ack       (mem_ack),
        .mem_req_valid (mem_req_valid),
        .mem_req_we    (mem_req_we),
        .mem_req_addr  (mem_req_addr),
        .mem_req_wdata (mem_req_wdata),
        .rd_grant      (rd_grant),
        .drain_pop     (drain_pop)
    );

    assign rd_ready = rd_hit | rd_grant;
    assign rd_take  = rd_valid & rd_ready;

    // Register the read response one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
            rsp_fwd   <= 1'b0;
        end else begin
            rsp_valid <= rd_take;
            if (rd_take) begin
                rsp_data <= rd_hit ? fwd_data : mem_rdata;
                rsp_fwd  <= rd_hit;
            end
        end
    end

    // R3
    rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_take |=> rsp_valid);

    // R3
    rsp_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_take |=> !rsp_valid);

    // R4
    fwd_no_memread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_take && !(mem_req_valid && mem_ack && !mem_req_we)) |=> rsp_fwd);

    // R3
    read_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> !rd_go);

endmodule

// File: tb/write_buffer_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push stores and reads. The monitor builds
// the expected drains and responses from the requirements and compares them.
module write_buffer_tb;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int DEPTH = 4;
    localparam logic [31:0] MASK = 32'h5A5A_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int mem_rd_cnt = 0;

    typedef struct { logic [31:0] a; logic [31:0] d; } wr_t;
    typedef struct { logic [31:0] d; logic f; } rsp_t;
    wr_t  exp_wq[$];
    rsp_t exp_rq[$];

    // Forwarding instance
    logic wr_valid = 0, rd_valid = 0, mem_ack = 0;
    logic [31:0] wr_addr = 0, wr_data = 0, rd_addr = 0;
    logic wr_ready, rd_ready, rsp_valid, rsp_fwd, mem_req_valid, mem_req_we;
    logic [31:0] rsp_data, mem_req_addr, mem_req_wdata, mem_rdata;
    assign mem_rdata = mem_req_addr ^ MASK;

    write_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .FORWARD_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_fwd(rsp_fwd),
        .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata));

    // Wait-for-empty instance
    logic w_wr_valid = 0, w_rd_valid = 0, w_mem_ack = 0;
    logic [31:0] w_wr_addr = 0, w_wr_data = 0, w_rd_addr = 0;
    logic w_wr_ready, w_rd_ready, w_rsp_valid, w_rsp_fwd, w_mem_req_valid, w_mem_req_we;
    logic [31:0] w_rsp_data, w_mem_req_addr, w_mem_req_wdata, w_mem_rdata;
    assign w_mem_rdata = w_mem_req_addr ^ MASK;

    write_buffer #(.AW(AW), .DW(DW), .DEPTH(DEPTH), .FORWARD_EN(1'b0)) u_dut_wait (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(w_wr_valid), .wr_ready(w_wr_ready), .wr_addr(w_wr_addr), .wr_data(w_wr_data),
        .rd_valid(w_rd_valid), .rd_ready(w_rd_ready), .rd_addr(w_rd_addr),
        .rsp_valid(w_rsp_valid), .rsp_data(w_rsp_data), .rsp_fwd(w_rsp_fwd),
        .mem_req_valid(w_mem_req_valid), .mem_req_we(w_mem_req_we),
        .mem_req_addr(w_mem_req_addr), .mem_req_wdata(w_mem_req_wdata),
        .mem_ack(w_mem_ack), .mem_rdata(w_mem_rdata));

    task automatic chk(input bit c, input string r, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!c) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic push_wr(input logic [31:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_valid = 1; wr_addr = a; wr_data = d;
        do @(negedge clk); while (!wr_ready);
        @(posedge clk); #1;
        wr_valid = 0;
    endtask

    task automatic rd_req(input logic [31:0] a);
        @(posedge clk); #1;
        rd_valid = 1; rd_addr = a;
        do @(negedge clk); while (!rd_ready);
        @(posedge clk); #1;
        rd_valid = 0;
    endtask

    task automatic set_ack(input logic v);
        @(posedge clk); #1;
        mem_ack = v;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (exp_wq.size() != 0 || exp_rq.size() != 0);
    endtask

    // Monitor: responses, then read acceptance, then drains, then pushes.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) begin
                if (exp_rq.size() == 0) begin
                    chk(1'b0, "R3", rsp_data, 32'h0);
                end else begin
                    rsp_t e;
                    e = exp_rq.pop_front();
                    chk(rsp_data == e.d && rsp_fwd == e.f, e.f ? "R4" : "R3",
                        {rsp_fwd, rsp_data[30:0]}, {e.f, e.d[30:0]});
                end
            end
            if (rd_valid && rd_ready) begin
                rsp_t e;
                bit found;
                found = 1'b0;
                e.d = rd_addr ^ MASK;
                e.f = 1'b0;
                foreach (exp_wq[i]) if (exp_wq[i].a == rd_addr) begin
                    found = 1'b1;
                    e.d = exp_wq[i].d;
                    e.f = 1'b1;
                end
                if (!found)
                    chk(mem_req_valid && !mem_req_we && mem_ack && mem_req_addr == rd_addr,
                        "R3", mem_req_addr, rd_addr);
                exp_rq.push_back(e);
            end
            if (mem_req_valid && mem_ack && mem_req_we) begin
                if (exp_wq.size() == 0) begin
                    chk(1'b0, "R2", mem_req_addr, 32'h0);
                end else begin
                    wr_t w;
                    w = exp_wq.pop_front();
                    chk(mem_req_addr == w.a && mem_req_wdata == w.d, "R2",
                        mem_req_addr, w.a);
                end
            end
            if (mem_req_valid && mem_ack && !mem_req_we) mem_rd_cnt++;
            if (wr_valid && wr_ready) exp_wq.push_back('{a: wr_addr, d: wr_data});
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
            finish_run();
        end
    end

    initial begin
        int n0;
        int drains;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R8 reset state
        @(negedge clk);
        chk(wr_ready == 1, "R8", wr_ready, 1);
        chk(mem_req_valid == 0, "R8", mem_req_valid, 0);
        chk(rsp_valid == 0, "R8", rsp_valid, 0);

        // R1 fill to DEPTH with memory stalled
        for (int i = 0; i < DEPTH; i++) push_wr(32'h100 + 4 * i, 32'hD000 + i);
        @(negedge clk);
        chk(wr_ready == 0, "R1", wr_ready, 0);
        chk(mem_req_valid && mem_req_we && mem_req_addr == 32'h100, "R2", mem_req_addr, 32'h100);

        // R3 non-matching read takes the port ahead of the full queue
        @(posedge clk); #1;
        rd_valid = 1; rd_addr = 32'h200;
        @(negedge clk);
        chk(mem_req_valid && !mem_req_we && mem_req_addr == 32'h200, "R3", mem_req_addr, 32'h200);
        chk(rd_ready == 0, "R3", rd_ready, 0);
        @(posedge clk); #1;
        mem_ack = 1;
        @(negedge clk);
        chk(rd_ready == 1, "R3", rd_ready, 1);
        @(posedge clk); #1;
        rd_valid = 0;
        wait_idle();

        // R5 / R4 duplicates in the buffer, memory stalled
        set_ack(0);
        push_wr(32'h300, 32'hA1);
        push_wr(32'h304, 32'hB2);
        push_wr(32'h300, 32'hA3);
        n0 = mem_rd_cnt;
        rd_req(32'h300);
        @(negedge clk);
        chk(rsp_valid && rsp_data == 32'hA3 && rsp_fwd, "R5", rsp_data, 32'hA3);
        rd_req(32'h304);
        @(negedge clk);
        chk(rsp_valid && rsp_data == 32'hB2 && rsp_fwd, "R4", rsp_data, 32'hB2);
        chk(mem_rd_cnt == n0, "R4", mem_rd_cnt, n0);
        set_ack(1);
        wait_idle();

        // R6 forward from the entry draining in the same cycle
        set_ack(0);
        push_wr(32'h400, 32'hC4);
        @(posedge clk); #1;
        mem_ack = 1; rd_valid = 1; rd_addr = 32'h400;
        @(negedge clk);
        chk(rd_ready && mem_req_valid && mem_req_we && mem_req_addr == 32'h400, "R6",
            mem_req_addr, 32'h400);
        @(posedge clk); #1;
        rd_valid = 0;
        @(negedge clk);
        chk(rsp_valid && rsp_data == 32'hC4 && rsp_fwd, "R6", rsp_data, 32'hC4);
        wait_idle();

        // R2 streaming pushes with interleaved misses and memory on
        for (int i = 0; i < 10; i++) begin
            push_wr(32'h800 + 4 * i, 32'hE00 + i);
            if (i % 3 == 0) rd_req(32'h900 + i);
        end
        rd_req(32'h804 + 4 * 9);
        wait_idle();
        chk(exp_wq.size() == 0, "R2", exp_wq.size(), 0);

        // R7 wait-for-empty variant
        for (int i = 0; i < 2; i++) begin
            @(posedge clk); #1;
            w_wr_valid = 1; w_wr_addr = 32'h500 + 4 * i; w_wr_data = 32'hF0 + i;
            @(negedge clk);
            chk(w_wr_ready == 1, "R1", w_wr_ready, 1);
        end
        @(posedge clk); #1;
        w_wr_valid = 0;
        w_rd_valid = 1; w_rd_addr = 32'h600;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(!w_rd_ready && !(w_mem_req_valid && !w_mem_req_we), "R7", w_mem_req_we, 1);
        end
        @(posedge clk); #1;
        w_mem_ack = 1;
        drains = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (w_mem_req_valid && w_mem_ack && w_mem_req_we) begin
                chk(w_mem_req_addr == 32'h500 + 4 * drains && w_mem_req_wdata == 32'hF0 + drains,
                    "R2", w_mem_req_addr, 32'h500 + 4 * drains);
                drains++;
            end
            if (w_rd_ready) break;
        end
        chk(drains == 2, "R7", drains, 2);
        chk(w_rd_ready && !w_mem_req_we && w_mem_req_addr == 32'h600, "R7", w_mem_req_addr, 32'h600);
        @(posedge clk); #1;
        w_rd_valid = 0;
        @(negedge clk);
        chk(w_rsp_valid && w_rsp_data == (32'h600 ^ MASK) && !w_rsp_fwd, "R7",
            w_rsp_data, 32'h600 ^ MASK);

        repeat (2) @(negedge clk);
        chk(exp_rq.size() == 0, "R3", exp_rq.size(), 0);
        finish_run();
    end

endmodule